// File: doc/BRIEF.md
# Two-Flop Encoded Ring Counter

This block walks a single high bit around four outputs. Each clock with the count enable high moves the bit one place up, and after the top place it wraps back to the bottom. The default build stores the ring position as a 2-bit binary code in two flip-flops. A small decoder turns that code into the four one-hot outputs. Every 2-bit code stands for a real ring position, so the counter can never sit in an illegal pattern, even if it starts up without a reset.

A build parameter can select a second form for comparison. That form is a plain four-flop rotating register, and reset loads its starting pattern directly. In both forms the position is also brought out as a 2-bit code, so a neighbour can use the compact value without encoding it again. Reset is asynchronous and active low. The enable is sampled on the rising clock edge.

Top module: `ring_counter4`

## Requirements
- R1: While rst_n is low, q is 4'b0001 and pos_code is 2'b00, at once and without waiting for a clock edge, in both forms.
- R2: On each rising edge with rst_n high and adv high, q steps through 0001, 0010, 0100, 1000 and then back to 0001.
- R3: pos_code and q always agree: code 00 with q 0001, code 01 with 0010, code 10 with 0100, and code 11 with 1000.
- R4: A rising edge with adv low leaves q and pos_code unchanged.
- R5: In the encoded form, pos_code rises by one on each enabled edge, and 11 wraps to 00.
- R6: Exactly one bit of q is high in every cycle.
- R7: In the four-flop form, an enabled edge rotates q left by one place, with bit 3 moving into bit 0.
- R8: When rst_n is low on an edge where adv is high, reset wins and the outputs stay at 0001 / 00.
- R9: If adv is already high when rst_n is released, the first rising edge after the release moves q to 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low, forces position 0 |
| adv | input | 1 | Step enable, sampled on the rising edge |
| q | output | 4 | One-hot ring output |
| pos_code | output | 2 | Binary ring position (index of the high bit of q) |

## Verification
Two pairs of inputs can act in the same cycle. The first is reset and step: the bench holds adv high while it pulls rst_n low across an edge. Reset must win, so the outputs stay at position 0 (R8). The second is reset release and step: the bench releases rst_n with adv already high, and the next edge must land exactly on position 1 (R9). Both forms are driven with the same stimulus and compared against a single position model, so any difference in how the two forms settle these overlaps shows up as a mismatch.

// File: rtl/ring_pkg.sv
package ring_pkg;
   typedef enum logic {
      FORM_ENCODED = 1'b0,
      FORM_SHIFT   = 1'b1
   } ring_form_e;

   localparam int unsigned RING_LEN = 4;
endpackage

// File: rtl/ring_code_ctr.sv
module ring_code_ctr #(
   parameter int unsigned CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [CW-1:0] code
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code <= '0;
      else if (adv)
         code <= code + CW'(1);
   end
endmodule

// File: rtl/ring_code_dec.sv
module ring_code_dec #(
   parameter int unsigned N  = 4,
   parameter int unsigned CW = 2
) (
   input  logic [CW-1:0] code,
   output logic [N-1:0]  onehot
);
   always_comb begin
      for (int i = 0; i < N; i++)
         onehot[i] = (code == CW'(i));
   end
endmodule

// File: rtl/ring_shift_reg.sv
module ring_shift_reg #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [N-1:0] ring
);
   localparam logic [N-1:0] START = N'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ring <= START;
      else if (adv)
         ring <= {ring[N-2:0], ring[N-1]};
   end
endmodule

// File: rtl/ring_onehot_enc.sv
module ring_onehot_enc #(
   parameter int unsigned N  = 4,
   parameter int unsigned CW = 2
) (
   input  logic [N-1:0]  onehot,
   output logic [CW-1:0] code
);
   always_comb begin
      code = '0;
      for (int i = 0; i < N; i++)
         if (onehot[i]) code = code | CW'(i);
   end
endmodule

// File: rtl/ring_counter4.sv
module ring_counter4 #(
   parameter ring_pkg::ring_form_e FORM = ring_pkg::FORM_ENCODED,
   parameter int unsigned          N    = ring_pkg::RING_LEN
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv,
   output logic [N-1:0]         q,
   output logic [$clog2(N)-1:0] pos_code
);
   localparam int unsigned CW = $clog2(N);

   if (N != 4) begin : g_len_bad
      $error("ring_counter4: N must be 4");
   end

   if (FORM == ring_pkg::FORM_ENCODED) begin : g_enc
      logic [CW-1:0] code_r;

      ring_code_ctr #(.CW(CW)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .adv   (adv),
         .code  (code_r)
      );

      ring_code_dec #(.N(N), .CW(CW)) u_dec (
         .code   (code_r),
         .onehot (q)
      );

      assign pos_code = code_r;
   end else begin : g_shift
      logic [N-1:0] ring_r;

      ring_shift_reg #(.N(N)) u_ring (
         .clk   (clk),
         .rst_n (rst_n),
         .adv   (adv),
         .ring  (ring_r)
      );

      ring_onehot_enc #(.N(N), .CW(CW)) u_enc (
         .onehot (ring_r),
         .code   (pos_code)
      );

      assign q = ring_r;
   end
endmodule

// File: rtl/ring_counter4_chk.sv
module ring_counter4_chk #(
   parameter ring_pkg::ring_form_e FORM = ring_pkg::FORM_ENCODED,
   parameter int unsigned          N    = 4,
   parameter int unsigned          CW   = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          adv,
   input logic [N-1:0]  q,
   input logic [CW-1:0] pos_code
);
   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_pos_chk: assert (q == N'(1) && pos_code == '0)
            else $error("reset position wrong");
      end
   end

   // R2
   rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> q == {$past(q[N-2:0]), $past(q[N-1])});

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(q) && $stable(pos_code)));

   // R5
   code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> pos_code == $past(pos_code) + CW'(1));

   // R6
   single_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(q) == 1);
endmodule

bind ring_counter4 ring_counter4_chk #(.FORM(FORM), .N(N), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .adv      (adv),
   .q        (q),
   .pos_code (pos_code)
);

// File: tb/tb_ring_counter4.sv
module tb_ring_counter4;
   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       adv = 1'b0;
   logic [3:0] q_e, q_s;
   logic [1:0] c_e, c_s;

   int  checks = 0;
   int  failures = 0;
   int  pos = 0;
   bit  done = 1'b0;

   typedef struct {
      int    p;
      string tag;
   } item_t;

   item_t exp_q[$];

   always #(PERIOD/2) clk = ~clk;

   ring_counter4 #(.FORM(ring_pkg::FORM_ENCODED)) dut (
      .clk(clk), .rst_n(rst_n), .adv(adv), .q(q_e), .pos_code(c_e));

   ring_counter4 #(.FORM(ring_pkg::FORM_SHIFT)) dut_shift (
      .clk(clk), .rst_n(rst_n), .adv(adv), .q(q_s), .pos_code(c_s));

   task automatic check(input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // driver: apply inputs at the falling edge, push the expected position
   task automatic drive(input logic r, input logic a, input string tag);
      item_t it;
      @(negedge clk);
      rst_n = r;
      adv   = a;
      if (!r)     pos = 0;
      else if (a) pos = (pos + 1) % 4;
      it.p   = pos;
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   // monitor: compare a quarter period after each rising edge
   always @(posedge clk) begin
      #(PERIOD/4);
      if (exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         check(it.tag, "enc q",    int'(q_e), 1 << it.p);
         check(it.tag, "enc code", int'(c_e), it.p);
         check(it.tag, "shift q",    int'(q_s), 1 << it.p);
         check(it.tag, "shift code", int'(c_s), it.p);
         check("R3", "enc map",   int'(q_e), 1 << c_e);
         check("R3", "shift map", int'(q_s), 1 << c_s);
         check("R6", "enc hot count", $countones(q_e), 1);
      end
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) drive(1'b0, 1'b0, "R1");
      // R9 release with enable already high
      drive(1'b1, 1'b1, "R9");
      // R2 full sequence and wrap
      repeat (8) drive(1'b1, 1'b1, "R2");
      // R4 hold
      repeat (3) drive(1'b1, 1'b0, "R4");
      // R5 mixed enable pattern, code wrap
      for (int i = 0; i < 12; i++) drive(1'b1, (i % 3) != 0, "R5");
      // R1 asynchronous effect between edges
      @(negedge clk);
      #1;
      rst_n = 1'b0;
      #1;
      check("R1", "async enc q",   int'(q_e), 1);
      check("R1", "async shift q", int'(q_s), 1);
      check("R1", "async code",    int'(c_e), 0);
      pos = 0;
      // R8 reset wins over enable
      repeat (2) drive(1'b0, 1'b1, "R8");
      drive(1'b1, 1'b1, "R9");
      // R7 rotation of the four-flop form
      repeat (6) drive(1'b1, 1'b1, "R7");
      drive(1'b1, 1'b0, "R4");
      drive(1'b1, 1'b1, "R7");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule